// File: doc/BRIEF.md
# Trace resource selection unit

This block turns raw trace status signals into a numbered set of boolean resources and uses one of them to drive timestamp requests. Resource 0 is always false and resource 1 is always true. Resources 2 up to 2*NUM_PAIRS-1 are programmable selectors. Each selector has a control word that picks one input group and a 16-bit mask. The selector is true when any masked bit of that group is set, and it can be inverted.

Selectors form pairs (2k, 2k+1). A pair result is the AND of its two members, optionally inverted. An 8-bit event selector, written separately, names either one resource or one pair. The timestamp request output is high in every cycle in which the named resource or pair is true. A typical setup points one selector at a counter-at-zero flag. The event selector then names that selector, so that a self-reloading counter produces a periodic timestamp request.

Top module: `trace_res_sel`

## Requirements
- R1: After reset `res_out` is 0 except bit 1, which is 1, all selector control words are 0, the event selector is 0, and `ts_req` is 0.
- R2: `res_out[0]` is always 0 and `res_out[1]` is always 1. Control writes to index 0 or 1 have no effect.
- R3: Control word bits 19:16 give the group and bits 15:0 the mask. The selector value is the OR of (group vector AND mask). Group 0 is `ext_in`, group 1 is `cmp_match`, and group 2 is counter-at-zero flags in bits 0..NUM_CNT-1 with the sequencer state one-hot in the next NUM_SEQ bits. Groups 3..15 read as all zero, and an empty mask gives 0. Bits above an input's width read as 0.
- R4: Control bit 20 inverts the selector's own value.
- R5: Selector outputs are registered. An input change in cycle n appears on `res_out` after the next clock edge, and a control write captured at edge t is reflected on `res_out` after edge t+1.
- R6: Event selector single mode (bit 7 = 0, bits 6:5 = 0): `ts_req` = `res_out[bits 4:0]`, or 0 for an index at or above 2*NUM_PAIRS. Non-zero bits 6:5 force `ts_req` to 0. `ts_req` follows `res_out` in the same cycle, so a counter reaching zero raises `ts_req` one edge later.
- R7: Event selector pair mode (bit 7 = 1, bits 6:5 = 0, bit 4 ignored): for pair k = bits 3:0, `ts_req` = (res[2k] AND res[2k+1]) XOR pair-invert. Pair-invert is control bit 21 of either member, ORed. Pair 0 and pairs at or above NUM_PAIRS give 0.
- R8: Control writes to an index at or above 2*NUM_PAIRS are ignored. In particular they do not alias onto a lower index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Selector control write strobe |
| cfg_wr_idx | input | IDX_W | Target selector index |
| cfg_wr_data | input | 22 | Control word: 21 pair-invert, 20 invert, 19:16 group, 15:0 mask |
| ts_wr_en | input | 1 | Event selector write strobe |
| ts_wr_data | input | 8 | Event selector value |
| ext_in | input | EXT_W | Group 0 status inputs |
| cmp_match | input | CMP_W | Group 1 status inputs |
| cnt_zero | input | NUM_CNT | Counter-at-zero flags (group 2, low bits) |
| seq_state | input | NUM_SEQ | One-hot sequencer state (group 2, above counters) |
| res_out | output | 2*NUM_PAIRS | Resource value vector |
| ts_req | output | 1 | Timestamp insertion request |

## Verification
The main stimulus is a long random run. Group codes, masks and invert bits are drawn from all values, including reserved groups and empty masks, against sparse counter flags and dense comparator and external inputs. A mix-up between groups, or mask bits landing in the wrong place, shows up as a mismatch on `res_out`. Random event selector bytes cover single, pair and reserved encodings, which separates pair-index decoding from single-index decoding. Directed cases then isolate specific faults. One counter flag is stepped to expose the one-edge latency. Writes to indices that alias lower ones when truncated catch missing range checks. Pair 0, out-of-range pairs and pair inversion from each member catch errors in the pair logic.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int MASK_W   = 16;
  localparam int CTRL_W   = 22;
  localparam int INV_BIT  = 20;
  localparam int PINV_BIT = 21;

  localparam logic [3:0] GRP_EXT    = 4'd0;
  localparam logic [3:0] GRP_CMP    = 4'd1;
  localparam logic [3:0] GRP_CNTSEQ = 4'd2;

  typedef struct packed {
    logic              pair_inv;
    logic              inv;
    logic [3:0]        grp;
    logic [MASK_W-1:0] mask;
  } sel_ctrl_t;

  typedef struct packed {
    logic       is_pair;
    logic [1:0] rsvd;
    logic [4:0] idx;
  } ev_sel_t;

  function automatic sel_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] d);
    sel_ctrl_t c;
    c.pair_inv = d[PINV_BIT];
    c.inv      = d[INV_BIT];
    c.grp      = d[19:16];
    c.mask     = d[15:0];
    return c;
  endfunction

  function automatic logic mask_hit(input logic [MASK_W-1:0] vec,
                                    input logic [MASK_W-1:0] mask);
    return |(vec & mask);
  endfunction
endpackage

// File: rtl/trs_group_pack.sv
module trs_group_pack #(
  parameter int EXT_W   = 8,
  parameter int CMP_W   = 8,
  parameter int NUM_CNT = 4,
  parameter int NUM_SEQ = 4
) (
  input  logic [EXT_W-1:0]   ext_in,
  input  logic [CMP_W-1:0]   cmp_match,
  input  logic [NUM_CNT-1:0] cnt_zero,
  input  logic [NUM_SEQ-1:0] seq_state,
  output logic [15:0]        ext_vec,
  output logic [15:0]        cmp_vec,
  output logic [15:0]        cs_vec
);
  always_comb begin
    ext_vec = '0;
    ext_vec[EXT_W-1:0] = ext_in;
    cmp_vec = '0;
    cmp_vec[CMP_W-1:0] = cmp_match;
    cs_vec = '0;
    cs_vec[NUM_CNT-1:0] = cnt_zero;
    cs_vec[NUM_CNT +: NUM_SEQ] = seq_state;
  end
endmodule

// File: rtl/trs_selector.sv
module trs_selector
  import trs_pkg::*;
#(
  parameter int MY_IDX  = 2,
  parameter int NUM_SEL = 8,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [15:0]       ext_vec,
  input  logic [15:0]       cmp_vec,
  input  logic [15:0]       cs_vec,
  output logic              res_q,
  output logic              pinv_q
);
  sel_ctrl_t   ctrl_q;
  logic        wr_hit;
  logic [15:0] grp_vec;
  logic        hit;

  assign wr_hit = wr_en && (wr_idx == IDX_W'(MY_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= unpack_ctrl(wr_data);
  end

  always_comb begin
    case (ctrl_q.grp)
      GRP_EXT:    grp_vec = ext_vec;
      GRP_CMP:    grp_vec = cmp_vec;
      GRP_CNTSEQ: grp_vec = cs_vec;
      default:    grp_vec = '0;
    endcase
  end

  assign hit = mask_hit(grp_vec, ctrl_q.mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= 1'b0;
    else        res_q <= hit ^ ctrl_q.inv;
  end

  assign pinv_q = ctrl_q.pair_inv;

  p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mask == '0) |=> (res_q == $past(ctrl_q.inv)));

  p_or_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_vec & ctrl_q.mask) != '0) |=> (res_q != $past(ctrl_q.inv)));

  p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDX_W'(NUM_SEL))) |=> $stable(ctrl_q));
endmodule

// File: rtl/trs_event_sel.sv
module trs_event_sel
  import trs_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int NUM_SEL   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts_wr_en,
  input  logic [7:0]           ts_wr_data,
  input  logic [NUM_SEL-1:0]   res_vec,
  input  logic [NUM_PAIRS-1:1] pinv_vec,
  output logic                 ts_req
);
  ev_sel_t     ev_q;
  logic [31:0] res_pad;
  logic [15:0] pair_pad;
  logic        rsvd_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ev_q <= '0;
    else if (ts_wr_en) ev_q <= ev_sel_t'(ts_wr_data);
  end

  always_comb begin
    res_pad = '0;
    res_pad[NUM_SEL-1:0] = res_vec;
  end

  assign pair_pad[0] = 1'b0;
  for (genvar k = 1; k < 16; k++) begin : g_pair
    if (k < NUM_PAIRS) begin : g_live
      assign pair_pad[k] = (res_vec[2*k] & res_vec[2*k+1]) ^ pinv_vec[k];
    end else begin : g_dead
      assign pair_pad[k] = 1'b0;
    end
  end

  assign rsvd_set = |ev_q.rsvd;

  always_comb begin
    if (rsvd_set)        ts_req = 1'b0;
    else if (ev_q.is_pair) ts_req = pair_pad[ev_q.idx[3:0]];
    else                 ts_req = res_pad[ev_q.idx];
  end

  p_pair0_false_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q.is_pair && ev_q.idx[3:0] == 4'd0) |-> !ts_req);

  p_true_res_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctrl_single_one(ev_q)) |-> ts_req);

  function automatic logic ev_ctrl_single_one(input ev_sel_t e);
    return !e.is_pair && (e.rsvd == 2'b00) && (e.idx == 5'd1);
  endfunction
endmodule

// File: rtl/trace_res_sel.sv
module trace_res_sel #(
  parameter int NUM_PAIRS = 4,
  parameter int NUM_CNT   = 4,
  parameter int NUM_SEQ   = 4,
  parameter int EXT_W     = 8,
  parameter int CMP_W     = 8,
  localparam int NUM_SEL  = 2 * NUM_PAIRS,
  localparam int IDX_W    = $clog2(NUM_SEL) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [IDX_W-1:0]     cfg_wr_idx,
  input  logic [21:0]          cfg_wr_data,
  input  logic                 ts_wr_en,
  input  logic [7:0]           ts_wr_data,
  input  logic [EXT_W-1:0]     ext_in,
  input  logic [CMP_W-1:0]     cmp_match,
  input  logic [NUM_CNT-1:0]   cnt_zero,
  input  logic [NUM_SEQ-1:0]   seq_state,
  output logic [NUM_SEL-1:0]   res_out,
  output logic                 ts_req
);
  logic [15:0]          ext_vec, cmp_vec, cs_vec;
  logic [NUM_SEL-1:2]   sel_pinv;
  logic [NUM_PAIRS-1:1] pair_pinv;

  trs_group_pack #(
    .EXT_W(EXT_W), .CMP_W(CMP_W), .NUM_CNT(NUM_CNT), .NUM_SEQ(NUM_SEQ)
  ) u_pack (
    .ext_in(ext_in), .cmp_match(cmp_match), .cnt_zero(cnt_zero),
    .seq_state(seq_state), .ext_vec(ext_vec), .cmp_vec(cmp_vec), .cs_vec(cs_vec)
  );

  assign res_out[0] = 1'b0;
  assign res_out[1] = 1'b1;

  for (genvar i = 2; i < NUM_SEL; i++) begin : g_sel
    trs_selector #(.MY_IDX(i), .NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
      .wr_data(cfg_wr_data), .ext_vec(ext_vec), .cmp_vec(cmp_vec),
      .cs_vec(cs_vec), .res_q(res_out[i]), .pinv_q(sel_pinv[i])
    );
  end

  for (genvar k = 1; k < NUM_PAIRS; k++) begin : g_pinv
    assign pair_pinv[k] = sel_pinv[2*k] | sel_pinv[2*k+1];
  end

  trs_event_sel #(.NUM_PAIRS(NUM_PAIRS), .NUM_SEL(NUM_SEL)) u_ev (
    .clk(clk), .rst_n(rst_n), .ts_wr_en(ts_wr_en), .ts_wr_data(ts_wr_data),
    .res_vec(res_out), .pinv_vec(pair_pinv), .ts_req(ts_req)
  );
endmodule

// File: tb/trace_res_sel_bench.sv
module trace_res_sel_bench;
  localparam int NP = 4, NC = 4, NQ = 4, EW = 8, CW = 8;
  localparam int NS = 2 * NP;
  localparam int IW = $clog2(NS) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [IW-1:0] cfg_wr_idx = '0;
  logic [21:0] cfg_wr_data = '0;
  logic ts_wr_en = 1'b0;
  logic [7:0] ts_wr_data = '0;
  logic [EW-1:0] ext_in = '0;
  logic [CW-1:0] cmp_match = '0;
  logic [NC-1:0] cnt_zero = '0;
  logic [NQ-1:0] seq_state = '0;
  logic [NS-1:0] res_out;
  logic ts_req;

  int n_chk = 0, n_err = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_res_sel #(.NUM_PAIRS(NP), .NUM_CNT(NC), .NUM_SEQ(NQ), .EXT_W(EW), .CMP_W(CW))
  u_trace_res_sel (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .ts_wr_en(ts_wr_en), .ts_wr_data(ts_wr_data),
    .ext_in(ext_in), .cmp_match(cmp_match), .cnt_zero(cnt_zero),
    .seq_state(seq_state), .res_out(res_out), .ts_req(ts_req)
  );

  // reference model
  logic [21:0]   m_ctrl [NS];
  logic [7:0]    m_ev;
  logic [NS-1:0] m_res;

  function automatic logic model_sel(input logic [21:0] c);
    logic [15:0] v;
    logic any;
    v = 16'h0;
    case (c[19:16])
      4'd0: for (int b = 0; b < EW; b++) v[b] = ext_in[b];
      4'd1: for (int b = 0; b < CW; b++) v[b] = cmp_match[b];
      4'd2: begin
        for (int b = 0; b < NC; b++) v[b] = cnt_zero[b];
        for (int b = 0; b < NQ; b++) v[NC+b] = seq_state[b];
      end
      default: v = 16'h0;
    endcase
    any = 1'b0;
    for (int b = 0; b < 16; b++) if (v[b] && c[b]) any = 1'b1;
    return c[20] ? !any : any;
  endfunction

  function automatic logic model_ts(input logic [7:0] e, input logic [NS-1:0] r);
    int k;
    if (e[6:5] != 2'b00) return 1'b0;
    if (e[7]) begin
      k = int'(e[3:0]);
      if (k == 0 || k >= NP) return 1'b0;
      return (r[2*k] & r[2*k+1]) ^ (m_ctrl[2*k][21] | m_ctrl[2*k+1][21]);
    end
    k = int'(e[4:0]);
    if (k >= NS) return 1'b0;
    return r[k];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_ctrl[i] <= '0;
      m_ev  <= '0;
      m_res <= {{(NS-2){1'b0}}, 2'b10};
    end else begin
      for (int i = 2; i < NS; i++) m_res[i] <= model_sel(m_ctrl[i]);
      if (cfg_wr_en && int'(cfg_wr_idx) >= 2 && int'(cfg_wr_idx) < NS)
        m_ctrl[cfg_wr_idx] <= cfg_wr_data;
      if (ts_wr_en) m_ev <= ts_wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison, 1 ns before each rising edge
  always @(negedge clk) begin
    #3;
    if (chk_on && rst_n && !done) begin
      check("R3,R4,R5 res_out", 32'(res_out), 32'(m_res));
      check("R6,R7 ts_req", 32'(ts_req), 32'(model_ts(m_ev, m_res)));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sel(input int idx, input logic [21:0] d);
    cfg_wr_en = 1'b1; cfg_wr_idx = IW'(idx); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wr_ev(input logic [7:0] d);
    ts_wr_en = 1'b1; ts_wr_data = d;
    @(negedge clk);
    ts_wr_en = 1'b0;
  endtask

  task automatic settle_check(input string tag, input logic [31:0] act_dummy);
    act_dummy = act_dummy;
    #3;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    step(3);
    #3;
    check("R1 reset res_out", 32'(res_out), 32'h2);
    check("R1 reset ts_req", 32'(ts_req), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    step(1); #3;
    check("R1 after release res_out", 32'(res_out), 32'h2);

    // R2: fixed entries ignore writes
    @(negedge clk);
    wr_sel(0, 22'h1F_FFFF);
    wr_sel(1, 22'h10_0000);
    wr_ev(8'h00);
    ext_in = '1;
    step(2); #3;
    check("R2 fixed res_out[1:0]", 32'(res_out[1:0]), 32'h2);
    check("R2 ts on resource 0", 32'(ts_req), 32'h0);

    // R3: empty mask and group routing
    @(negedge clk);
    wr_sel(2, 22'h00_0000);
    wr_sel(3, 22'h01_0004);
    wr_sel(6, 22'h03_FFFF);
    cmp_match = 8'h04;
    step(2); #3;
    check("R3 empty mask", 32'(res_out[2]), 32'h0);
    check("R3 group1 hit", 32'(res_out[3]), 32'h1);
    check("R3 reserved group", 32'(res_out[6]), 32'h0);

    // R4: invert
    @(negedge clk);
    wr_sel(2, 22'h10_0000);
    step(2); #3;
    check("R4 inverted empty", 32'(res_out[2]), 32'h1);

    // R5 and R6: counter-at-zero latency to ts_req
    @(negedge clk);
    wr_sel(2, 22'h00_0000);
    wr_sel(4, 22'h02_0002);
    wr_ev(8'h04);
    cnt_zero = '0;
    step(2);
    cnt_zero = 4'b0010;
    #3;
    check("R5 res before edge", 32'(res_out[4]), 32'h0);
    check("R6 ts before edge", 32'(ts_req), 32'h0);
    @(negedge clk); #3;
    check("R5 res after edge", 32'(res_out[4]), 32'h1);
    check("R6 ts after edge", 32'(ts_req), 32'h1);

    // R3: sequencer state bit in group 2 (mask bit NC+2)
    @(negedge clk);
    seq_state = 4'b0100;
    wr_sel(5, 22'h02_0040);
    step(2); #3;
    check("R3 sequencer state", 32'(res_out[5]), 32'h1);

    // R7: pair behaviour
    @(negedge clk);
    wr_ev(8'h82);
    #3;
    check("R7 pair2 and", 32'(ts_req), 32'h1);
    @(negedge clk);
    wr_sel(5, 22'h22_0040);
    #3;
    check("R7 pinv from odd member", 32'(ts_req), 32'h0);
    @(negedge clk);
    wr_ev(8'h92);
    #3;
    check("R7 bit4 ignored", 32'(ts_req), 32'h0);
    @(negedge clk);
    wr_sel(5, 22'h02_0040);
    wr_ev(8'h80);
    #3;
    check("R7 pair0 false", 32'(ts_req), 32'h0);
    @(negedge clk);
    wr_ev(8'h85);
    #3;
    check("R7 pair out of range", 32'(ts_req), 32'h0);
    @(negedge clk);
    wr_ev(8'hA2);
    #3;
    check("R7 reserved bits block", 32'(ts_req), 32'h0);

    // R6: out-of-range single index must not alias resource 1
    @(negedge clk);
    wr_ev(8'h09);
    #3;
    check("R6 single out of range", 32'(ts_req), 32'h0);
    @(negedge clk);
    wr_ev(8'h01);
    #3;
    check("R6 single true resource", 32'(ts_req), 32'h1);

    // R8: write to 10 must not land on selector 2
    @(negedge clk);
    wr_sel(10, 22'h10_0000);
    step(2); #3;
    check("R8 no alias write", 32'(res_out[2]), 32'h0);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      ext_in    = EW'($urandom);
      cmp_match = CW'($urandom);
      for (int b = 0; b < NC; b++) cnt_zero[b] = ($urandom % 4) == 0;
      seq_state = NQ'(1 << ($urandom % NQ));
      cfg_wr_en = ($urandom % 8) == 0;
      cfg_wr_idx = IW'($urandom % 16);
      cfg_wr_data = {$urandom % 2 == 0, $urandom % 2 == 0, 4'($urandom % 5),
                     ($urandom % 4 == 0) ? 16'h0 : 16'($urandom)};
      ts_wr_en = ($urandom % 16) == 0;
      ts_wr_data = ($urandom % 2 == 0) ? 8'($urandom % NS)
                                       : 8'($urandom);
    end
    @(negedge clk);
    cfg_wr_en = 1'b0; ts_wr_en = 1'b0;
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule